// File: doc/BRIEF.md
# Peripheral Clock-Enable Reset Sequencer

This block brings a single peripheral up safely and later parks it again. A one-cycle request carries a direction. When the request turns the peripheral on and it is not already running, the sequencer holds the peripheral in reset, lets a short settling time pass, starts its clock, lets a long settling time pass, and only then lets go of reset. A request to turn the peripheral off stops its clock and never touches its reset. The block reads the present reset and clock-control bits to see whether the peripheral is already running. It drives one-cycle set and clear strobes into those bits.

Three parameters configure each instance. `HAS_RESET` says whether the peripheral owns a reset line. `RUN_LEVEL` gives the clock-control bit value that lets the clock run. `CLK_HZ` sets both wait times. The machine has seven states:

- `ST_IDLE`: waits for a request.
- `ST_RST_ON`: sets the reset bit and loads the short wait.
- `ST_WAIT_SHORT`: counts the short wait.
- `ST_CLK_RUN`: drives the clock bit to its run level and loads the long wait.
- `ST_WAIT_LONG`: counts the long wait.
- `ST_RST_OFF`: clears the reset bit.
- `ST_CLK_STOP`: drives the clock bit to its stop level.

The transitions are:

- `ST_IDLE` to `ST_RST_ON` on an on-request to a stopped peripheral that has a reset line.
- `ST_IDLE` to `ST_CLK_RUN` on the same request when there is no reset line.
- `ST_IDLE` to `ST_CLK_STOP` on an off-request.
- `ST_IDLE` stays in `ST_IDLE` on an on-request to a running peripheral.
- `ST_RST_ON` to `ST_WAIT_SHORT` always.
- `ST_WAIT_SHORT` to `ST_CLK_RUN` when the timer expires.
- `ST_CLK_RUN` to `ST_WAIT_LONG` when there is a reset line.
- `ST_CLK_RUN` to `ST_IDLE` or `ST_CLK_STOP` when there is no reset line.
- `ST_WAIT_LONG` to `ST_RST_OFF` when the timer expires.
- `ST_RST_OFF` to `ST_CLK_STOP` if an off-request came in during the sequence, otherwise to `ST_IDLE`.
- `ST_CLK_STOP` to `ST_IDLE` always.

Top module: `periph_wake_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy_o` and all four strobes are low.
- R2: The peripheral counts as running when both of these hold: its clock bit equals `RUN_LEVEL`, and `periph_in_reset` is 0 (this input is ignored when `HAS_RESET`=0). An on-request to a running peripheral produces no strobe, and `busy_o` stays low.
- R3: With `HAS_RESET`=1, an on-request to a stopped peripheral produces exactly three one-cycle strobes, in this order: reset set, clock run, reset clear.
- R4: The clock-run strobe comes SHORT+1 cycles after the reset-set strobe, with SHORT = max(CLK_HZ/10000, 1). The reset-clear strobe comes LONG+1 cycles after the clock-run strobe, with LONG = max(CLK_HZ/100, 1).
- R5: With `HAS_RESET`=0, an on-request to a stopped peripheral produces only a clock-run strobe. `busy_o` is high for exactly that one cycle, and no reset strobe is ever issued.
- R6: An off-request accepted in idle produces a single clock-stop strobe in the next cycle, and no reset strobe, so the reset bit keeps its value.
- R7: With `RUN_LEVEL`=0 the clock is run by `clk_clr_o` and stopped by `clk_set_o`. With `RUN_LEVEL`=1 the roles are swapped.
- R8: Every strobe is issued while `busy_o` is high. On-requests that arrive while `busy_o` is high are ignored and do not restart the sequence.
- R9: An off-request that arrives during an on-sequence is held. Its clock-stop strobe follows in the cycle right after the reset-clear strobe.
- R10: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_on | input | 1 | Request direction: 1 turns on, 0 turns off |
| periph_in_reset | input | 1 | Present value of the peripheral's reset bit (1 = held) |
| clk_ctl_bit | input | 1 | Present value of the peripheral's clock-control bit |
| rst_set_o | output | 1 | Strobe that sets the reset bit |
| rst_clr_o | output | 1 | Strobe that clears the reset bit |
| clk_set_o | output | 1 | Strobe that sets the clock-control bit |
| clk_clr_o | output | 1 | Strobe that clears the clock-control bit |
| busy_o | output | 1 | High while a sequence is in progress |

## Verification
The assertions check properties that must hold in every cycle. Only one strobe may be high at a time, and every strobe must fall inside a busy window. The exact gaps between the reset-set, clock-run and reset-clear strobes are measured by counters in the checker. A no-reset instance must never issue a reset strobe. An idle on-request to a running peripheral must leave the block idle, and an idle off-request must be followed by a stop strobe. The bench scenarios are needed for the rest. They show the final values of the modelled reset and clock bits for every starting state, that an on-request during busy does not restart the sequence, that a held off-request follows the release, and that the polarity is swapped on the inverted instance.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
package pws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_WAIT_SHORT,
        ST_CLK_RUN,
        ST_WAIT_LONG,
        ST_RST_OFF,
        ST_CLK_STOP
    } pws_state_e;

    // Number of clock cycles in 1/per of a second, never below one.
    function automatic int unsigned wait_cycles(input int unsigned hz, input int unsigned per);
        int unsigned q;
        q = hz / per;
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/pws_timer.sv
`timescale 1ns/1ps
module pws_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pws_fsm.sv
`timescale 1ns/1ps
module pws_fsm
    import pws_pkg::*;
#(
    parameter bit          HAS_RESET = 1'b1,
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] SHORT_LD = '0,
    parameter logic [W-1:0] LONG_LD  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_on,
    input  logic         periph_up,
    input  logic         tmr_expired,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         do_rst_on,
    output logic         do_rst_off,
    output logic         do_run,
    output logic         do_stop,
    output logic         busy
);

    pws_state_e state, state_n;
    logic       pend_off;
    logic       off_seen;

    assign off_seen = pend_off | (req_valid & ~req_on);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Off-request held while an on-sequence runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_off <= 1'b0;
        end else if (state == ST_IDLE || state == ST_CLK_STOP) begin
            pend_off <= 1'b0;
        end else if (req_valid && !req_on) begin
            pend_off <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_on) begin
                        state_n = ST_CLK_STOP;
                    end else if (!periph_up) begin
                        state_n = HAS_RESET ? ST_RST_ON : ST_CLK_RUN;
                    end
                end
            end
            ST_RST_ON:     state_n = ST_WAIT_SHORT;
            ST_WAIT_SHORT: if (tmr_expired) state_n = ST_CLK_RUN;
            ST_CLK_RUN: begin
                if (HAS_RESET) begin
                    state_n = ST_WAIT_LONG;
                end else begin
                    state_n = off_seen ? ST_CLK_STOP : ST_IDLE;
                end
            end
            ST_WAIT_LONG:  if (tmr_expired) state_n = ST_RST_OFF;
            ST_RST_OFF:    state_n = off_seen ? ST_CLK_STOP : ST_IDLE;
            ST_CLK_STOP:   state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        do_rst_on  = 1'b0;
        do_rst_off = 1'b0;
        do_run     = 1'b0;
        do_stop    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        busy       = (state != ST_IDLE);
        unique case (state)
            ST_RST_ON: begin
                do_rst_on = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = SHORT_LD;
            end
            ST_CLK_RUN: begin
                do_run   = 1'b1;
                tmr_load = HAS_RESET;
                tmr_val  = LONG_LD;
            end
            ST_RST_OFF:  do_rst_off = 1'b1;
            ST_CLK_STOP: do_stop    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/periph_wake_seq.sv
`timescale 1ns/1ps
module periph_wake_seq
    import pws_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 200_000_000,
    parameter bit          HAS_RESET = 1'b1,
    parameter bit          RUN_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_on,
    input  logic periph_in_reset,
    input  logic clk_ctl_bit,
    output logic rst_set_o,
    output logic rst_clr_o,
    output logic clk_set_o,
    output logic clk_clr_o,
    output logic busy_o
);

    localparam int unsigned SHORT_CYC = wait_cycles(CLK_HZ, 10000);
    localparam int unsigned LONG_CYC  = wait_cycles(CLK_HZ, 100);
    localparam int unsigned TW        = $clog2(LONG_CYC + 1);
    localparam logic [TW-1:0] SHORT_LD = TW'(SHORT_CYC - 1);
    localparam logic [TW-1:0] LONG_LD  = TW'(LONG_CYC - 1);

    logic          periph_up;
    logic          clk_running;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          do_rst_on, do_rst_off, do_run, do_stop;

    assign clk_running = (clk_ctl_bit == RUN_LEVEL);

    generate
        if (HAS_RESET) begin : g_with_reset
            assign periph_up = clk_running & ~periph_in_reset;
        end else begin : g_no_reset
            assign periph_up = clk_running;
        end
    endgenerate

    pws_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pws_fsm #(
        .HAS_RESET (HAS_RESET),
        .W         (TW),
        .SHORT_LD  (SHORT_LD),
        .LONG_LD   (LONG_LD)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_on      (req_on),
        .periph_up   (periph_up),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .do_rst_on   (do_rst_on),
        .do_rst_off  (do_rst_off),
        .do_run      (do_run),
        .do_stop     (do_stop),
        .busy        (busy_o)
    );

    assign rst_set_o = do_rst_on;
    assign rst_clr_o = do_rst_off;

    generate
        if (RUN_LEVEL) begin : g_set_runs
            assign clk_set_o = do_run;
            assign clk_clr_o = do_stop;
        end else begin : g_clear_runs
            assign clk_set_o = do_stop;
            assign clk_clr_o = do_run;
        end
    endgenerate

endmodule

// File: rtl/pws_check.sv
`timescale 1ns/1ps
module pws_check
    import pws_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 200_000_000,
    parameter bit          HAS_RESET = 1'b1,
    parameter bit          RUN_LEVEL = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_on,
    input logic periph_in_reset,
    input logic clk_ctl_bit,
    input logic rst_set_o,
    input logic rst_clr_o,
    input logic clk_set_o,
    input logic clk_clr_o,
    input logic busy_o
);

    localparam int unsigned SHORT_CYC = wait_cycles(CLK_HZ, 10000);
    localparam int unsigned LONG_CYC  = wait_cycles(CLK_HZ, 100);

    logic        run_s, stop_s, up;
    logic        arm_a, arm_b;
    logic [31:0] cnt_a, cnt_b;

    assign run_s  = RUN_LEVEL ? clk_set_o : clk_clr_o;
    assign stop_s = RUN_LEVEL ? clk_clr_o : clk_set_o;
    assign up     = (clk_ctl_bit == RUN_LEVEL) && (!HAS_RESET || !periph_in_reset);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_a <= 1'b0;
            arm_b <= 1'b0;
            cnt_a <= '0;
            cnt_b <= '0;
        end else begin
            if (rst_set_o) begin
                arm_a <= 1'b1;
                cnt_a <= 32'd1;
            end else if (run_s) begin
                arm_a <= 1'b0;
            end else if (cnt_a != 32'hFFFF_FFFF) begin
                cnt_a <= cnt_a + 32'd1;
            end
            if (run_s && arm_a) begin
                arm_b <= 1'b1;
                cnt_b <= 32'd1;
            end else if (rst_clr_o) begin
                arm_b <= 1'b0;
            end else if (cnt_b != 32'hFFFF_FFFF) begin
                cnt_b <= cnt_b + 32'd1;
            end
        end
    end

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rst_set_o, rst_clr_o, clk_set_o, clk_clr_o}) <= 1);

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_set_o || rst_clr_o || clk_set_o || clk_clr_o) |-> busy_o);

    assert_run_after_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s && HAS_RESET) |-> arm_a);

    assert_short_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_s && arm_a) |-> (cnt_a == SHORT_CYC + 1));

    assert_long_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_clr_o |-> (arm_b && cnt_b == LONG_CYC + 1));

    assert_no_rst_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_RESET |-> !(rst_set_o || rst_clr_o));

    assert_up_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid && req_on && up) |=> !busy_o);

    assert_off_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid && !req_on) |=> (stop_s && busy_o && !rst_set_o && !rst_clr_o));

endmodule

bind periph_wake_seq pws_check #(
    .CLK_HZ    (CLK_HZ),
    .HAS_RESET (HAS_RESET),
    .RUN_LEVEL (RUN_LEVEL)
) u_pws_check (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_on          (req_on),
    .periph_in_reset (periph_in_reset),
    .clk_ctl_bit     (clk_ctl_bit),
    .rst_set_o       (rst_set_o),
    .rst_clr_o       (rst_clr_o),
    .clk_set_o       (clk_set_o),
    .clk_clr_o       (clk_clr_o),
    .busy_o          (busy_o)
);

// File: tb/test_periph_wake_seq.sv
`timescale 1ns/1ps
module test_periph_wake_seq;

    localparam int unsigned HZ    = 200_000;
    localparam int unsigned SHORT = HZ / 10000;
    localparam int unsigned LONG  = HZ / 100;

    // Walk table for instance 0 (reset line, clear-to-run):
    // {preset_rst, preset_clk, on, busy_expected, final_rst, final_clk}
    localparam logic [5:0] VEC [7] = '{
        6'b001_000,  // running: nothing happens (R2)
        6'b101_100,  // held in reset, clock running: full sequence
        6'b011_100,  // clock stopped: full sequence
        6'b111_100,  // both: full sequence
        6'b000_101,  // off from running (R6)
        6'b100_111,  // off while in reset: reset kept (R6)
        6'b010_101   // off when already stopped
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] req_valid, req_on;
    logic [2:0] m_rst, m_clk;
    logic [2:0] pre_en, pre_r, pre_c;
    logic [2:0] busy, rs, rc, cs, cc;

    int cyc = 0;
    int n_rs [3];
    int n_rc [3];
    int n_cs [3];
    int n_cc [3];
    int t_rs, t_run, t_rc, t_stop;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < 3; g++) begin : g_dut
        periph_wake_seq #(
            .CLK_HZ    (HZ),
            .HAS_RESET (g != 1),
            .RUN_LEVEL (g == 2)
        ) i_periph_wake_seq (
            .clk             (clk),
            .rst_n           (rst_n),
            .req_valid       (req_valid[g]),
            .req_on          (req_on[g]),
            .periph_in_reset (m_rst[g]),
            .clk_ctl_bit     (m_clk[g]),
            .rst_set_o       (rs[g]),
            .rst_clr_o       (rc[g]),
            .clk_set_o       (cs[g]),
            .clk_clr_o       (cc[g]),
            .busy_o          (busy[g])
        );
    end

    // Model of the peripheral's reset and clock-control bits
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int g = 0; g < 3; g++) begin
            if (pre_en[g]) begin
                m_rst[g] <= pre_r[g];
                m_clk[g] <= pre_c[g];
            end else begin
                if (rs[g]) m_rst[g] <= 1'b1;
                if (rc[g]) m_rst[g] <= 1'b0;
                if (cs[g]) m_clk[g] <= 1'b1;
                if (cc[g]) m_clk[g] <= 1'b0;
            end
        end
    end

    // Strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < 3; g++) begin
                if (rs[g]) n_rs[g] <= n_rs[g] + 1;
                if (rc[g]) n_rc[g] <= n_rc[g] + 1;
                if (cs[g]) n_cs[g] <= n_cs[g] + 1;
                if (cc[g]) n_cc[g] <= n_cc[g] + 1;
            end
            if (rs[0]) t_rs   <= cyc;
            if (cc[0]) t_run  <= cyc;
            if (rc[0]) t_rc   <= cyc;
            if (cs[0]) t_stop <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic preset(input int idx, input logic r, input logic c);
        @(negedge clk);
        pre_en[idx] = 1'b1;
        pre_r[idx]  = r;
        pre_c[idx]  = c;
        @(negedge clk);
        pre_en[idx] = 1'b0;
    endtask

    task automatic do_req(input int idx, input logic on);
        @(negedge clk);
        req_valid[idx] = 1'b1;
        req_on[idx]    = on;
        @(negedge clk);
        req_valid[idx] = 1'b0;
    endtask

    task automatic wait_idle(input int idx);
        for (int k = 0; k < int'(SHORT + LONG) + 50; k++) begin
            if (!busy[idx]) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int b_rs, b_rc, b_cs, b_cc;
        logic bsy;
        rst_n = 1'b0;
        req_valid = '0; req_on = '0;
        pre_en = '0; pre_r = '0; pre_c = '0;
        m_rst = '0; m_clk = '0;
        for (int g = 0; g < 3; g++) begin
            n_rs[g] = 0; n_rc[g] = 0; n_cs[g] = 0; n_cc[g] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: quiet during and right after reset
        chk({busy, rs, rc, cs, cc} == '0, "R1 in reset", int'({busy, rs, rc, cs, cc}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, rs, rc, cs, cc} == '0, "R1 after reset", int'({busy, rs, rc, cs, cc}), 0);

        // Table walk on instance 0
        for (int v = 0; v < 7; v++) begin
            preset(0, VEC[v][5], VEC[v][4]);
            b_rs = n_rs[0]; b_rc = n_rc[0]; b_cs = n_cs[0]; b_cc = n_cc[0];
            do_req(0, VEC[v][3]);
            bsy = busy[0];
            wait_idle(0);
            chk(bsy == VEC[v][2], "R2/R8 busy", int'(bsy), int'(VEC[v][2]));
            chk(m_rst[0] == VEC[v][1], "R6 final reset bit", int'(m_rst[0]), int'(VEC[v][1]));
            chk(m_clk[0] == VEC[v][0], "R7 final clock bit", int'(m_clk[0]), int'(VEC[v][0]));
            if (VEC[v][3] && VEC[v][2]) begin
                chk(n_rs[0] - b_rs == 1 && n_rc[0] - b_rc == 1 && n_cc[0] - b_cc == 1,
                    "R3 strobe counts", n_rs[0] - b_rs + n_rc[0] - b_rc + n_cc[0] - b_cc, 3);
                chk(t_run - t_rs == int'(SHORT) + 1, "R4 short gap", t_run - t_rs, SHORT + 1);
                chk(t_rc - t_run == int'(LONG) + 1, "R4 long gap", t_rc - t_run, LONG + 1);
            end else if (VEC[v][3]) begin
                chk(n_rs[0] + n_rc[0] + n_cs[0] + n_cc[0] == b_rs + b_rc + b_cs + b_cc,
                    "R2 no strobes", n_rs[0] + n_rc[0] + n_cs[0] + n_cc[0], b_rs + b_rc + b_cs + b_cc);
            end else begin
                chk(n_rs[0] == b_rs && n_rc[0] == b_rc && n_cs[0] - b_cs == 1,
                    "R6 stop only", n_cs[0] - b_cs, 1);
            end
        end

        // R8: second on-request during a sequence does not restart it
        preset(0, 1'b1, 1'b1);
        b_rs = n_rs[0];
        do_req(0, 1'b1);
        repeat (10) @(negedge clk);
        do_req(0, 1'b1);
        wait_idle(0);
        chk(n_rs[0] - b_rs == 1, "R8 single reset set", n_rs[0] - b_rs, 1);
        chk(t_rc - t_rs == int'(SHORT + LONG) + 2, "R8 no restart", t_rc - t_rs, SHORT + LONG + 2);

        // R9: off-request during the on-sequence is held until release
        preset(0, 1'b1, 1'b1);
        do_req(0, 1'b1);
        repeat (5) @(negedge clk);
        do_req(0, 1'b0);
        wait_idle(0);
        chk(t_stop == t_rc + 1, "R9 stop after release", t_stop - t_rc, 1);
        chk(m_rst[0] == 1'b0 && m_clk[0] == 1'b1, "R9 final bits",
            int'({m_rst[0], m_clk[0]}), 1);

        // R5/R2: instance without reset line ignores the reset input
        preset(1, 1'b1, 1'b0);
        b_rs = n_rs[1]; b_cc = n_cc[1];
        do_req(1, 1'b1);
        chk(busy[1] == 1'b0 && n_cc[1] == b_cc, "R2 no-reset running", int'(busy[1]), 0);
        preset(1, 1'b1, 1'b1);
        b_rs = n_rs[1]; b_rc = n_rc[1]; b_cc = n_cc[1];
        do_req(1, 1'b1);
        chk(busy[1] == 1'b1, "R5 busy first cycle", int'(busy[1]), 1);
        @(negedge clk);
        chk(busy[1] == 1'b0, "R5 busy one cycle", int'(busy[1]), 0);
        chk(n_cc[1] - b_cc == 1 && n_rs[1] == b_rs && n_rc[1] == b_rc,
            "R5 clock only", n_cc[1] - b_cc, 1);
        chk(m_clk[1] == 1'b0 && m_rst[1] == 1'b1, "R5 final bits",
            int'({m_rst[1], m_clk[1]}), 2);

        // R7: inverted polarity instance
        preset(2, 1'b0, 1'b0);
        b_cs = n_cs[2]; b_cc = n_cc[2];
        do_req(2, 1'b1);
        wait_idle(2);
        chk(n_cs[2] - b_cs == 1 && n_cc[2] == b_cc, "R7 run by set", n_cs[2] - b_cs, 1);
        chk(m_clk[2] == 1'b1 && m_rst[2] == 1'b0, "R7 inverted final",
            int'({m_rst[2], m_clk[2]}), 1);
        b_cs = n_cs[2]; b_cc = n_cc[2];
        do_req(2, 1'b0);
        wait_idle(2);
        chk(n_cc[2] - b_cc == 1 && n_cs[2] == b_cs, "R7 stop by clear", n_cc[2] - b_cc, 1);
        chk(m_clk[2] == 1'b0, "R7 inverted stopped", int'(m_clk[2]), 0);

        // R10: one strobe per cycle across a full sequence is held by the
        // checker; confirm the idle state afterwards
        chk({rs, rc, cs, cc} == '0, "R10 idle strobes", int'({rs, rc, cs, cc}), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule